// File: doc/BRIEF.md
# Programmable Twisted-Ring Clock Divider

This block divides its input clock by an even ratio that can be chosen while it runs. A chain of rising-edge flops forms a twisted ring, also called a Johnson counter. The first stage loads the inverse of a selectable tap stage, and every later stage copies the stage before it. A 3-bit select input sets the tap, so code k makes a ring of k+1 stages and divides by 2·(k+1). The divided clock comes straight from the first stage, so its duty cycle is exactly half.

A new select value goes through a register first. It reaches the ring only at the one point in each period where the whole chain is zero. Because of this, a change never leaves the ring in an illegal state and never produces a runt pulse. Stages outside the active length are forced to zero.

The active-low reset asserts asynchronously and is released through a two-flop synchronizer. Every flop therefore starts from a known zero state, whatever level the clock has when it starts.

Top module: `jdiv_clkdiv`

## Requirements
- R1: With select code k (bits [2:0] of the select input, read as unsigned), each output period lasts 2·(k+1) input clock cycles. Code 0 divides by 2 and code 7 divides by 16.
- R2: In steady state, the output stays high for exactly k+1 input cycles and then low for exactly k+1 input cycles.
- R3: The output is the first ring stage. It rises only on the edge that follows a cycle in which every ring stage was zero.
- R4: While the reset input is low, the output is low, and it goes low as soon as reset asserts, without waiting for a clock edge. After reset is released, the output stays low through the first two rising edges and goes high on the third.
- R5: A new select value applies only from the next all-zero point of the ring. The period already under way finishes with the old ratio, and the following period uses the new ratio.
- R6: Ring stages above the active tap always hold zero. When the ring is lengthened, the new periods are therefore exact.
- R7: If the select input changes and then returns to its earlier value before the ring's next all-zero point, the output is unaffected.
- R8: Once reset has been released, the output never carries an unknown value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; all flops use its rising edge |
| rst_ni | input | 1 | Reset, active low: asserts asynchronously, releases synchronously |
| ratio_sel_i | input | 3 | Ratio code k; the divide ratio is 2·(k+1) |
| div_clk_o | output | 1 | Divided clock with a 50% duty cycle |

## Verification
The embedded assertions check on every cycle the properties of the ring's structure:
- the output rises only out of the all-zero chain;
- stages above the tap stay clear;
- the active tap changes only at an all-zero point;
- the synchronizer releases in order;
- the output is never unknown.

Only the directed scenarios can show the properties that depend on counting over whole periods:
- the exact high and low lengths for every code;
- the reset-release latency;
- that a change takes effect exactly one period later;
- that a select pulse falling between two all-zero points leaves the output unchanged.

// File: rtl/jdiv_pkg.sv
package jdiv_pkg;
  // Default width of the ratio select; the ring holds 2**width stages.
  localparam int JDIV_SEL_W = 3;

  // Divide ratio produced by a given select code.
  function automatic int jdiv_ratio(input int code);
    return 2 * (code + 1);
  endfunction
endpackage

// File: rtl/jdiv_rst_sync.sv
module jdiv_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;

  // R4
  rst_release_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> $past(meta_q));
endmodule

// File: rtl/jdiv_ratio_ctl.sv
module jdiv_ratio_ctl #(
  parameter int SEL_W = jdiv_pkg::JDIV_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ring_zero_i,
  output logic [SEL_W-1:0] tap_o
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [SEL_W-1:0] tap_q, tap_d;
  logic             tap_en;

  // The staged select may move the tap only at the all-zero point of the ring.
  always_comb begin
    sel_d  = sel_i;
    tap_en = ring_zero_i;
    tap_d  = tap_en ? sel_q : tap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      tap_q <= '0;
    end else begin
      sel_q <= sel_d;
      tap_q <= tap_d;
    end
  end

  assign tap_o = tap_q;

  // R5
  tap_change_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tap_q) |-> $past(ring_zero_i));
endmodule

// File: rtl/jdiv_ring.sv
module jdiv_ring #(
  parameter int SEL_W  = jdiv_pkg::JDIV_SEL_W,
  parameter int NSTAGE = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  tap_i,
  output logic [NSTAGE-1:0] ring_o
);
  logic [NSTAGE-1:0] ring_q, ring_d;

  // The head stage takes the inverse of the selected tap stage.
  assign ring_d[0] = ~ring_q[tap_i];

  // Each later stage copies its neighbour while it lies inside the active
  // length, and is cleared once it lies beyond the tap.
  for (genvar i = 1; i < NSTAGE; i++) begin : g_stage
    assign ring_d[i] = (SEL_W'(i) <= tap_i) ? ring_q[i-1] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= '0;
    end else begin
      ring_q <= ring_d;
    end
  end

  assign ring_o = ring_q;

  // R3
  rise_from_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ring_q[0]) |-> $past(ring_q == '0));

  // R6
  idle_stage_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_q) <= int'(tap_i) + 1);
endmodule

// File: rtl/jdiv_clkdiv.sv
module jdiv_clkdiv #(
  parameter int SEL_W = jdiv_pkg::JDIV_SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] ratio_sel_i,
  output logic             div_clk_o
);
  localparam int NSTAGE = 1 << SEL_W;

  logic              rst_sync_n;
  logic [SEL_W-1:0]  tap;
  logic [NSTAGE-1:0] ring;
  logic              ring_zero;

  jdiv_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  jdiv_ratio_ctl #(.SEL_W(SEL_W)) u_ratio_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (ratio_sel_i),
    .ring_zero_i (ring_zero),
    .tap_o       (tap)
  );

  jdiv_ring #(.SEL_W(SEL_W), .NSTAGE(NSTAGE)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tap_i  (tap),
    .ring_o (ring)
  );

  assign ring_zero = (ring == '0);
  assign div_clk_o = ring[0];

  // R8
  out_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(div_clk_o));
endmodule

// File: tb/jdiv_clkdiv_tb.sv
module jdiv_clkdiv_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] sel;
  logic       dclk;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         x_seen = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  jdiv_clkdiv u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ratio_sel_i (sel),
    .div_clk_o   (dclk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = dclk;
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if ($isunknown(dclk)) x_seen = 1'b1;
      if (dclk === 1'b1 && prev === 1'b0) return;
      prev = dclk;
    end
  endtask

  // The current sample is at level lvl; count it and the samples after it that
  // hold the same level, and stop at the first sample that differs.
  task automatic count_run(input logic lvl, output int n);
    n = 1;
    for (int g = 0; g < 64; g++) begin
      @(negedge clk);
      if ($isunknown(dclk)) x_seen = 1'b1;
      if (dclk === lvl) n++;
      else break;
    end
  endtask

  task automatic t_reset();
    int hi;
    sel = 3'd3;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(dclk === 1'b0, "R4 async low", int'(dclk), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dclk === 1'b0, "R4 low after edge 1", int'(dclk), 0);
    @(negedge clk);
    check(dclk === 1'b0, "R4 low after edge 2", int'(dclk), 0);
    @(negedge clk);
    check(dclk === 1'b1, "R4 R3 high after edge 3", int'(dclk), 1);
    count_run(1'b1, hi);
    check(hi == 4, "R2 first high phase", hi, 4);
  endtask

  task automatic t_ratio(input int k);
    int hi, lo;
    sel = 3'(k);
    wait_rise();
    wait_rise();
    count_run(1'b1, hi);
    count_run(1'b0, lo);
    check(hi == k + 1, $sformatf("R2 high k=%0d", k), hi, k + 1);
    check(hi + lo == jdiv_pkg::jdiv_ratio(k), $sformatf("R1 period k=%0d", k),
          hi + lo, jdiv_pkg::jdiv_ratio(k));
  endtask

  task automatic t_change(input int k_old, input int k_new);
    int h1, l1, h2, l2;
    sel = 3'(k_old);
    wait_rise();
    wait_rise();
    sel = 3'(k_new);
    count_run(1'b1, h1);
    count_run(1'b0, l1);
    count_run(1'b1, h2);
    count_run(1'b0, l2);
    check(h1 + l1 == 2 * (k_old + 1), $sformatf("R5 old period %0d->%0d", k_old, k_new),
          h1 + l1, 2 * (k_old + 1));
    check(h2 == k_new + 1 && l2 == k_new + 1,
          $sformatf("R5 R6 new period %0d->%0d", k_old, k_new), h2 + l2, 2 * (k_new + 1));
  endtask

  task automatic t_glitch();
    int h, lo;
    sel = 3'd7;
    wait_rise();
    wait_rise();
    sel = 3'd0;
    @(negedge clk);
    @(negedge clk);
    sel = 3'd7;
    count_run(1'b1, h);
    count_run(1'b0, lo);
    check(h + 2 == 8 && lo == 8, "R7 short select pulse ignored", h + 2 + lo, 16);
  endtask

  initial begin
    rst_n = 1'b0;
    sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    for (int k = 0; k < 8; k++) t_ratio(k);
    t_change(7, 0);
    t_change(0, 7);
    t_change(2, 5);
    t_glitch();
    check(!x_seen, "R8 no unknown output", int'(x_seen), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule